// File: doc/BRIEF.md
# Zone Write Filter with Page Lock Bytes

This unit stands between the write-command path and the byte array of one user zone. Every write request carries the protection mode of the zone, a start address, a byte count and up to sixteen data bytes. The unit decides for each requested byte whether it may be stored and what value is committed. Where that decision depends on stored contents, it fetches them through a synchronous read port. It then issues byte writes on a write port. When it has finished, it raises a one-cycle completion strobe together with a refused flag and a truncated flag.

There are four modes. Normal mode stores the bytes as given, and the addresses wrap inside their 16-byte page. Program-only mode can only clear bits. Modify-forbidden mode refuses everything. In page-lock mode, each 8-byte page has a guard byte at its lowest address. Each bit of the guard byte protects one byte of that page, and a zero bit blocks writes to that byte. The guard byte itself can only lose bits, and it freezes once its own bit 0 is cleared. In page-lock mode a request commits at most one byte.

Top module: `zone_wr_filter`

## Requirements
- R1: After reset, busy, done, rejected, partial, mem_wr_en and mem_rd_en are all 0. done is high for exactly one cycle per accepted request, and rejected/partial keep their values until the next request is accepted.
- R2: With req_mode = 2'b00 (normal), byte k of the request (req_data bits [8k+7:8k]) is written unchanged to address {req_addr[6:4], (req_addr[3:0]+k) mod 16}, for k = 0 .. N-1. N is req_count, and any count above 16 is treated as 16.
- R3: With req_mode = 2'b10 (program-only), each target byte is stored as (old value AND new byte). Wrapping and ordering are as in R2, and rejected stays 0.
- R4: With req_mode = 2'b01 (page-lock), the guard byte of a target is the byte at the target address with bits [2:0] cleared. A target at offset i (1..7) whose guard bit i is 0 is not written, and rejected is set.
- R5: In page-lock mode, a target at offset i (1..7) whose guard bit i is 1 is stored exactly as given. It is not ANDed with the old value.
- R6: In page-lock mode, a write to a guard byte (offset 0) stores (old AND new) when the stored guard bit 0 is 1. When that bit is 0, the write is refused, the byte is left unchanged and rejected is set.
- R7: In page-lock mode, only the first request byte is considered. partial is set when req_count is above 1, and no other address is written.
- R8: With req_mode = 2'b11 (modify-forbidden), no byte is written and rejected is set.
- R9: A request with req_count = 0 in a mode other than modify-forbidden writes nothing and completes with rejected = 0 and partial = 0.
- R10: req_valid is ignored while busy is 1. The request in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (taken only when idle) |
| req_mode | input | 2 | Zone protection mode |
| req_addr | input | 7 | Start byte address within the zone |
| req_count | input | 5 | Number of bytes requested |
| req_data | input | 128 | Request bytes, byte k in bits [8k+7:8k] |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle completion strobe |
| rejected | output | 1 | At least one byte was refused |
| partial | output | 1 | Request was cut to a single byte |
| mem_rd_en | output | 1 | Read strobe, data returns next cycle |
| mem_rd_addr | output | 7 | Read address |
| mem_rd_data | input | 8 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | 7 | Write address |
| mem_wr_data | output | 8 | Byte to commit |

## Verification
In a program-only request the write of byte k is committed in the same cycle as the read of byte k+1. The bench starts a three-byte program-only request that wraps across the page end, with different old contents at each address. It judges every stored byte against its own old value ANDed with its own new byte. The bench also drives a second request while the first is still writing, and checks that the second leaves no trace in memory or in the flags.

// File: rtl/zone_wr_filter_pkg.sv
package zone_wr_filter_pkg;

    typedef enum logic [1:0] {
        M_NORMAL = 2'b00,
        M_LOCK   = 2'b01,
        M_PROG   = 2'b10,
        M_FORBID = 2'b11
    } zmode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_EVAL,
        S_PUT,
        S_DONE
    } zstate_t;

endpackage

// File: rtl/zone_wr_addr_gen.sv
module zone_wr_addr_gen #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 5,
    parameter int PAGE_W = 4,
    parameter int LOCK_W = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  idx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] guard_addr,
    output logic [LOCK_W-1:0] guard_off
);
    logic [PAGE_W-1:0] in_page;

    always_comb begin
        in_page    = base[PAGE_W-1:0] + idx[PAGE_W-1:0];
        cur_addr   = {base[ADDR_W-1:PAGE_W], in_page};
        guard_addr = {cur_addr[ADDR_W-1:LOCK_W], {LOCK_W{1'b0}}};
        guard_off  = cur_addr[LOCK_W-1:0];
    end
endmodule

// File: rtl/zone_wr_lock_eval.sv
module zone_wr_lock_eval
    import zone_wr_filter_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LOCK_W = 3
) (
    input  zmode_t            mode,
    input  logic [LOCK_W-1:0] off,
    input  logic [BYTE_W-1:0] stored,
    input  logic [BYTE_W-1:0] incoming,
    output logic              allow,
    output logic [BYTE_W-1:0] commit
);
    always_comb begin
        allow  = 1'b1;
        commit = incoming;
        unique case (mode)
            M_PROG: begin
                commit = stored & incoming;
            end
            M_LOCK: begin
                if (off == '0) begin
                    allow  = stored[0];
                    commit = stored & incoming;
                end else begin
                    allow  = stored[off];
                    commit = incoming;
                end
            end
            default: begin
                allow  = (mode != M_FORBID);
                commit = incoming;
            end
        endcase
    end
endmodule

// File: rtl/zone_wr_filter.sv
module zone_wr_filter
    import zone_wr_filter_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_mode,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0] req_count,
    input  logic [MAX_BYTES*BYTE_W-1:0] req_data,
    output logic                        busy,
    output logic                        done,
    output logic                        rejected,
    output logic                        partial,
    output logic                        mem_rd_en,
    output logic [ADDR_W-1:0]           mem_rd_addr,
    input  logic [BYTE_W-1:0]           mem_rd_data,
    output logic                        mem_wr_en,
    output logic [ADDR_W-1:0]           mem_wr_addr,
    output logic [BYTE_W-1:0]           mem_wr_data
);
    localparam int CNT_W  = $clog2(MAX_BYTES+1);
    localparam int PAGE_W = $clog2(MAX_BYTES);
    localparam int LOCK_W = $clog2(BYTE_W);
    localparam int DATA_W = MAX_BYTES*BYTE_W;

    typedef struct packed {
        zstate_t            st;
        zmode_t             mode;
        logic [ADDR_W-1:0]  base;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   idx;
        logic [DATA_W-1:0]  data;
        logic               rej;
        logic               part;
        logic               wr_en;
        logic [ADDR_W-1:0]  wr_addr;
        logic [BYTE_W-1:0]  wr_data;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0] cur_addr, guard_addr;
    logic [LOCK_W-1:0] guard_off;
    logic [BYTE_W-1:0] new_byte, commit_byte;
    logic              allow;
    logic              last_byte;
    logic [CNT_W-1:0]  eff_cnt;

    zone_wr_addr_gen #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .LOCK_W(LOCK_W)
    ) u_addr (
        .base(r_q.base), .idx(r_q.idx),
        .cur_addr(cur_addr), .guard_addr(guard_addr), .guard_off(guard_off)
    );

    assign new_byte = r_q.data[r_q.idx*BYTE_W +: BYTE_W];

    zone_wr_lock_eval #(
        .BYTE_W(BYTE_W), .LOCK_W(LOCK_W)
    ) u_eval (
        .mode(r_q.mode), .off(guard_off), .stored(mem_rd_data),
        .incoming(new_byte), .allow(allow), .commit(commit_byte)
    );

    assign last_byte = (r_q.idx == r_q.cnt - CNT_W'(1));
    assign eff_cnt   = (req_count > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : req_count;

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.mode = zmode_t'(req_mode);
                    r_d.base = req_addr;
                    r_d.data = req_data;
                    r_d.idx  = '0;
                    r_d.cnt  = eff_cnt;
                    r_d.rej  = 1'b0;
                    r_d.part = 1'b0;
                    if (zmode_t'(req_mode) == M_FORBID) begin
                        r_d.rej = 1'b1;
                        r_d.st  = S_DONE;
                    end else if (eff_cnt == '0) begin
                        r_d.st = S_DONE;
                    end else if (zmode_t'(req_mode) == M_LOCK) begin
                        r_d.cnt  = CNT_W'(1);
                        r_d.part = (eff_cnt > CNT_W'(1));
                        r_d.st   = S_READ;
                    end else if (zmode_t'(req_mode) == M_PROG) begin
                        r_d.st = S_READ;
                    end else begin
                        r_d.st = S_PUT;
                    end
                end
            end
            S_READ: begin
                r_d.st = S_EVAL;
            end
            S_EVAL: begin
                if (allow) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = cur_addr;
                    r_d.wr_data = commit_byte;
                end else begin
                    r_d.rej = 1'b1;
                end
                if (last_byte) begin
                    r_d.st = S_DONE;
                end else begin
                    r_d.idx = r_q.idx + CNT_W'(1);
                    r_d.st  = S_READ;
                end
            end
            S_PUT: begin
                r_d.wr_en   = 1'b1;
                r_d.wr_addr = cur_addr;
                r_d.wr_data = new_byte;
                if (last_byte) begin
                    r_d.st = S_DONE;
                end else begin
                    r_d.idx = r_q.idx + CNT_W'(1);
                end
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, mode: M_NORMAL, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != S_IDLE);
    assign done        = (r_q.st == S_DONE);
    assign rejected    = r_q.rej;
    assign partial     = r_q.part;
    assign mem_rd_en   = (r_q.st == S_READ);
    assign mem_rd_addr = (r_q.mode == M_LOCK) ? guard_addr : cur_addr;
    assign mem_wr_en   = r_q.wr_en;
    assign mem_wr_addr = r_q.wr_addr;
    assign mem_wr_data = r_q.wr_data;

    // R8
    forbid_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.mode == M_FORBID) |-> !mem_wr_en);

    // R3 R6
    no_bit_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && (r_q.mode == M_PROG ||
                       (r_q.mode == M_LOCK && mem_wr_addr[LOCK_W-1:0] == '0)))
        |-> ((mem_wr_data & ~$past(mem_rd_data)) == '0));

    // R7
    lock_single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && r_q.mode == M_LOCK) |=> !mem_wr_en);

    // R2
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_addr[ADDR_W-1:PAGE_W] == r_q.base[ADDR_W-1:PAGE_W]));

    // R4
    guard_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && r_q.mode == M_LOCK) |-> (mem_rd_addr[LOCK_W-1:0] == '0));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/zone_wr_filter_tb.sv
`timescale 1ns/1ps
module zone_wr_filter_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   req_mode = 2'b00;
    logic [6:0]   req_addr = '0;
    logic [4:0]   req_count = '0;
    logic [127:0] req_data = '0;
    logic         busy, done, rejected, partial;
    logic         mem_rd_en, mem_wr_en;
    logic [6:0]   mem_rd_addr, mem_wr_addr;
    logic [7:0]   mem_rd_data, mem_wr_data;

    logic [7:0]   mem [128];
    int           wr_seen = 0;
    int           n_chk = 0, n_fail = 0;
    logic         got_rej, got_part;

    always #2 clk = ~clk;

    zone_wr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_addr(req_addr), .req_count(req_count), .req_data(req_data),
        .busy(busy), .done(done), .rejected(rejected), .partial(partial),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_seen <= wr_seen + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_mem(input int a, input logic [7:0] e, input string tag);
        chk(mem[a] === e, tag, int'(mem[a]), int'(e));
    endtask

    task automatic run_req(input logic [1:0] m, input logic [6:0] a, input logic [4:0] c,
                           input logic [127:0] d);
        @(negedge clk);
        wr_seen   = 0;
        req_mode  = m; req_addr = a; req_count = c; req_data = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        chk(done === 1'b1, "R1 done reached", int'(done), 1);
        got_rej  = rejected;
        got_part = partial;
        @(negedge clk);
        chk(done === 1'b0, "R1 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        chk(busy === 0 && done === 0 && rejected === 0 && partial === 0,
            "R1 reset flags", {busy, done, rejected, partial}, 0);
        chk(mem_wr_en === 0 && mem_rd_en === 0, "R1 reset strobes", {mem_wr_en, mem_rd_en}, 0);
    endtask

    task automatic t_normal;
        logic [127:0] d = '0;
        for (int k = 0; k < 5; k++) d[8*k +: 8] = 8'hA0 + 8'(k);
        mem[7'h20] = 8'h55;
        run_req(2'b00, 7'h1C, 5'd5, d);
        chk_mem(7'h1C, 8'hA0, "R2 byte0");
        chk_mem(7'h1F, 8'hA3, "R2 byte3");
        chk_mem(7'h10, 8'hA4, "R2 wrap");
        chk_mem(7'h20, 8'h55, "R2 next page untouched");
        chk(wr_seen == 5 && !got_rej && !got_part, "R2 count/flags", wr_seen, 5);
    endtask

    task automatic t_clamp;
        logic [127:0] d = '0;
        for (int k = 0; k < 16; k++) d[8*k +: 8] = 8'h10 + 8'(k);
        mem[7'h50] = 8'h77;
        run_req(2'b00, 7'h64, 5'd20, d);
        chk(wr_seen == 16, "R2 clamp to 16", wr_seen, 16);
        chk_mem(7'h63, 8'h1F, "R2 clamp last wraps");
        chk_mem(7'h50, 8'h77, "R2 clamp stays in page");
    endtask

    task automatic t_prog;
        logic [127:0] d = '0;
        mem[7'h3E] = 8'hF0; mem[7'h3F] = 8'h3C; mem[7'h30] = 8'hAA;
        d[7:0] = 8'h5F; d[15:8] = 8'hFF; d[23:16] = 8'h0F;
        run_req(2'b10, 7'h3E, 5'd3, d);
        chk_mem(7'h3E, 8'h50, "R3 and byte0");
        chk_mem(7'h3F, 8'h3C, "R3 and byte1");
        chk_mem(7'h30, 8'h0A, "R3 and wrapped byte2");
        chk(!got_rej, "R3 not rejected", int'(got_rej), 0);
    endtask

    task automatic t_lock;
        logic [127:0] d = '0;
        mem[7'h40] = 8'hD9;
        for (int k = 1; k < 8; k++) mem[7'h40 + k] = 8'h0C;
        d[7:0] = 8'h99;
        run_req(2'b01, 7'h41, 5'd1, d);
        chk_mem(7'h41, 8'h0C, "R4 locked offset1 unchanged");
        chk(got_rej && wr_seen == 0, "R4 locked rejected", int'(got_rej), 1);
        run_req(2'b01, 7'h45, 5'd1, d);
        chk(got_rej && mem[7'h45] == 8'h0C, "R4 locked offset5", int'(mem[7'h45]), 8'h0C);
        d[15:8] = 8'h66;
        run_req(2'b01, 7'h43, 5'd4, d);
        chk_mem(7'h43, 8'h99, "R5 open byte stored as given");
        chk_mem(7'h44, 8'h0C, "R7 second byte dropped");
        chk(got_part && !got_rej && wr_seen == 1, "R7 partial flag", int'(got_part), 1);
    endtask

    task automatic t_guard;
        logic [127:0] d = '0;
        d[7:0] = 8'hF6;
        run_req(2'b01, 7'h40, 5'd1, d);
        chk_mem(7'h40, 8'hD0, "R6 guard and");
        d[7:0] = 8'h00;
        run_req(2'b01, 7'h40, 5'd1, d);
        chk(got_rej && mem[7'h40] == 8'hD0, "R6 guard self-locked", int'(mem[7'h40]), 8'hD0);
        d[7:0] = 8'h11;
        run_req(2'b01, 7'h43, 5'd1, d);
        chk(got_rej && mem[7'h43] == 8'h99, "R4 newly locked offset3", int'(mem[7'h43]), 8'h99);
        mem[7'h48] = 8'h0F;
        d[7:0] = 8'hFF;
        run_req(2'b01, 7'h48, 5'd1, d);
        chk(!got_rej && mem[7'h48] == 8'h0F, "R6 guard bits not raised", int'(mem[7'h48]), 8'h0F);
    endtask

    task automatic t_forbid;
        logic [127:0] d = '1;
        mem[7'h50] = 8'h12; mem[7'h51] = 8'h34;
        run_req(2'b11, 7'h50, 5'd2, d);
        chk(got_rej && wr_seen == 0, "R8 forbidden rejected", wr_seen, 0);
        chk(mem[7'h50] == 8'h12 && mem[7'h51] == 8'h34, "R8 forbidden unchanged",
            int'(mem[7'h50]), 8'h12);
    endtask

    task automatic t_zero;
        logic [127:0] d = '1;
        mem[7'h70] = 8'h21;
        run_req(2'b00, 7'h70, 5'd0, d);
        chk(wr_seen == 0 && mem[7'h70] == 8'h21 && !got_rej && !got_part,
            "R9 zero count", wr_seen, 0);
    endtask

    task automatic t_busy;
        logic [127:0] d = '0;
        for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'hC0 + 8'(k);
        mem[7'h00] = 8'h5A;
        @(negedge clk);
        wr_seen = 0;
        req_mode = 2'b00; req_addr = 7'h78; req_count = 5'd4; req_data = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_mode = 2'b11; req_addr = 7'h00; req_count = 5'd1; req_data = '0;
        @(negedge clk);
        req_mode = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        got_rej = rejected;
        @(negedge clk);
        chk(!got_rej && wr_seen == 4, "R10 first request intact", wr_seen, 4);
        chk_mem(7'h7B, 8'hC3, "R10 last byte of first");
        chk_mem(7'h00, 8'h5A, "R10 second request ignored");
        chk(busy === 0, "R10 idle after", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_clamp();
        t_prog();
        t_lock();
        t_guard();
        t_forbid();
        t_zero();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule